// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the purely combinational computing stage of a small 8-bit accumulator processor. Every cycle the datapath gives it the current instruction's opcode, the accumulator, one operand byte that has already been fetched from a register, an immediate or memory, and the four current status flags: carry, zero, sign and parity. The block returns the accumulator value to write back, a write enable for the accumulator, and the next value of each of the four flags.

The arithmetic and logic group occupies opcodes 0x80 to 0xBF. Within that group, opcode bits [5:3] pick the operation and bits [2:0] only steer operand selection outside this block. A few more single-byte opcodes change the carry flag, complement the accumulator, or apply a decimal adjust. Any other opcode passes the accumulator and all flags through unchanged, with the write enable low. The sequencer uses the zero, sign, parity and carry results for its conditional branches.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 0x80–0x87 give A AND operand, 0x88–0x8F give A OR operand, and 0x90–0x97 give A XOR operand. Opcode bits [2:0] have no effect, and carry is left as it was.
- R2: Opcodes 0xA0–0xA7 give A + operand modulo 256. Carry becomes the unsigned carry out of bit 7, and the incoming carry is not added.
- R3: Opcodes 0xA8–0xAF give A + operand + carry-in modulo 256, with carry set to the carry out of bit 7.
- R4: Opcodes 0xB0–0xB7 give A − operand modulo 256. Carry is set exactly when a borrow occurs (A < operand).
- R5: Opcodes 0xB8–0xBF give A − operand − carry-in modulo 256. Carry is set exactly when A < operand + carry-in.
- R6: 0x98 rotates A left by one (bit 7 into bit 0) and 0x9A rotates it right by one (bit 0 into bit 7), both with carry unchanged. 0x99 rotates left through carry (old carry into bit 0, old bit 7 into carry), and 0x9B rotates right through carry (old carry into bit 7, old bit 0 into carry).
- R7: 0x9E gives A + 1, 0x9F gives A − 1 (both wrapping), and 0x0F gives the bitwise inverse of A. All three leave carry unchanged, and the operand has no effect.
- R8: 0x08 forces carry to 1, 0x09 forces it to 0 and 0x0E inverts it. These three opcodes keep the write enable low and leave the accumulator, zero, sign and parity unchanged.
- R9: 0xFA decimal-adjusts A. First 0x06 is added (modulo 256) if bits [3:0] exceed 9. Then 0x60 is added to that value if its bits [7:4] exceed 9 or carry-in is 1. Carry-out is carry-in OR the carry out of bit 7 of the second addition.
- R10: Whenever the write enable is high, zero is 1 exactly when the new accumulator is 0x00, sign equals bit 7 of the new accumulator, and parity is 1 exactly when the new accumulator holds an odd number of 1 bits.
- R11: Every opcode not named in R1–R9 (including 0x00, 0x9C, 0x9D, 0xC0–0xFF other than 0xFA) drives the write enable low, returns the accumulator input unchanged, and returns all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 8 | Opcode of the current instruction |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand, already selected by the datapath |
| cy_in | input | 1 | Current carry flag |
| zr_in | input | 1 | Current zero flag |
| sg_in | input | 1 | Current sign flag |
| pr_in | input | 1 | Current parity flag |
| acc_out | output | 8 | Accumulator value to write back |
| acc_we | output | 1 | High when the opcode writes the accumulator |
| cy_out | output | 1 | Next carry flag |
| zr_out | output | 1 | Next zero flag |
| sg_out | output | 1 | Next sign flag |
| pr_out | output | 1 | Next parity flag |

## Verification
The vector table pairs each operation with operand values chosen to separate it from its neighbours. AND, OR and XOR get overlapping bit patterns. Additions are tried with and without a carry out of bit 7 while the incoming carry is set, which shows whether carry-in leaks into plain addition. Subtractions are tried at equality, just below and just above, with and without a borrow-in. Rotates use end bits that tell the through-carry forms apart from the plain forms. The decimal adjust covers the low-nibble step, the high-nibble step, the case where the carry alone forces the second step, and the second step overflowing. Full sweeps of the accumulator through one add and one subtract-with-borrow opcode reach every carry, zero, sign and parity combination. Non-writing opcodes are given preset flag values that a wrongly decoded operation would disturb.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 8;

  typedef enum logic [4:0] {
    ALU_NONE,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_ROL,
    ALU_ROLC,
    ALU_ROR,
    ALU_RORC,
    ALU_INC,
    ALU_DEC,
    ALU_INV,
    ALU_ADD,
    ALU_ADDC,
    ALU_SUB,
    ALU_SUBB,
    ALU_DADJ,
    ALU_CSET,
    ALU_CCLR,
    ALU_CINV
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_PASS,
    SRC_BITS,
    SRC_ARITH,
    SRC_DADJ
  } res_src_e;

  typedef struct packed {
    logic cy;
    logic zr;
    logic sg;
    logic pr;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output alu_op_e         op_kind,
  output res_src_e        res_src,
  output logic            wr_acc
);

  localparam logic [1:0] GRP_ALU = 2'b10;

  logic [2:0] sub_sel;
  logic [2:0] low_sel;

  assign sub_sel = op_code[5:3];
  assign low_sel = op_code[2:0];

  always_comb begin
    op_kind = ALU_NONE;
    if (op_code[7:6] == GRP_ALU) begin
      case (sub_sel)
        3'd0: op_kind = ALU_AND;
        3'd1: op_kind = ALU_OR;
        3'd2: op_kind = ALU_XOR;
        3'd3: begin
          case (low_sel)
            3'd0:    op_kind = ALU_ROL;
            3'd1:    op_kind = ALU_ROLC;
            3'd2:    op_kind = ALU_ROR;
            3'd3:    op_kind = ALU_RORC;
            3'd6:    op_kind = ALU_INC;
            3'd7:    op_kind = ALU_DEC;
            default: op_kind = ALU_NONE;
          endcase
        end
        3'd4:    op_kind = ALU_ADD;
        3'd5:    op_kind = ALU_ADDC;
        3'd6:    op_kind = ALU_SUB;
        default: op_kind = ALU_SUBB;
      endcase
    end else begin
      case (op_code)
        8'h08:   op_kind = ALU_CSET;
        8'h09:   op_kind = ALU_CCLR;
        8'h0E:   op_kind = ALU_CINV;
        8'h0F:   op_kind = ALU_INV;
        8'hFA:   op_kind = ALU_DADJ;
        default: op_kind = ALU_NONE;
      endcase
    end
  end

  always_comb begin
    res_src = SRC_PASS;
    wr_acc  = 1'b0;
    case (op_kind)
      ALU_AND, ALU_OR, ALU_XOR, ALU_ROL, ALU_ROLC, ALU_ROR, ALU_RORC,
      ALU_INC, ALU_DEC, ALU_INV: begin
        res_src = SRC_BITS;
        wr_acc  = 1'b1;
      end
      ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBB: begin
        res_src = SRC_ARITH;
        wr_acc  = 1'b1;
      end
      ALU_DADJ: begin
        res_src = SRC_DADJ;
        wr_acc  = 1'b1;
      end
      default: begin
        res_src = SRC_PASS;
        wr_acc  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cy_in,
  input  logic         sub_en,
  input  logic         chain_en,
  output logic [W-1:0] sum_out,
  output logic         cy_out
);

  localparam int WIDE = W + 1;

  logic [WIDE-1:0] a_wide;
  logic [WIDE-1:0] b_wide;
  logic [WIDE-1:0] c_wide;
  logic [WIDE-1:0] total;

  assign a_wide = {1'b0, a_in};
  assign b_wide = {1'b0, b_in};
  assign c_wide = {{W{1'b0}}, chain_en & cy_in};

  always_comb begin
    if (sub_en) total = a_wide - b_wide - c_wide;
    else        total = a_wide + b_wide + c_wide;
  end

  // Bit W holds the carry for additions and the borrow for subtractions.
  assign sum_out = total[W-1:0];
  assign cy_out  = total[W];

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_kind,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cy_in,
  output logic [W-1:0] res_out,
  output logic         cy_out
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res_out = a_in;
    cy_out  = cy_in;
    case (op_kind)
      ALU_AND:  res_out = a_in & b_in;
      ALU_OR:   res_out = a_in | b_in;
      ALU_XOR:  res_out = a_in ^ b_in;
      ALU_ROL:  res_out = {a_in[W-2:0], a_in[W-1]};
      ALU_ROLC: begin
        res_out = {a_in[W-2:0], cy_in};
        cy_out  = a_in[W-1];
      end
      ALU_ROR:  res_out = {a_in[0], a_in[W-1:1]};
      ALU_RORC: begin
        res_out = {cy_in, a_in[W-1:1]};
        cy_out  = a_in[0];
      end
      ALU_INC:  res_out = a_in + ONE;
      ALU_DEC:  res_out = a_in - ONE;
      ALU_INV:  res_out = ~a_in;
      default: begin
        res_out = a_in;
        cy_out  = cy_in;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res_out,
  output logic              cy_out
);

  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
  localparam logic [DATA_W-1:0] LOW_FIX   = DATA_W'(6);
  localparam logic [DATA_W-1:0] HIGH_FIX  = DATA_W'(6) << NIB_W;

  logic              low_big;
  logic [DATA_W-1:0] step1;
  logic              high_big;
  logic              do_high;
  logic [DATA_W:0]   step2;

  assign low_big  = a_in[NIB_W-1:0] > DIGIT_MAX;
  assign step1    = low_big ? (a_in + LOW_FIX) : a_in;
  assign high_big = step1[DATA_W-1:NIB_W] > DIGIT_MAX;
  assign do_high  = high_big | cy_in;
  assign step2    = {1'b0, step1} + {1'b0, HIGH_FIX};

  assign res_out = do_high ? step2[DATA_W-1:0] : step1;
  assign cy_out  = cy_in | (do_high & step2[DATA_W]);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [7:0] op_code,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       cy_in,
  input  logic       zr_in,
  input  logic       sg_in,
  input  logic       pr_in,
  output logic [7:0] acc_out,
  output logic       acc_we,
  output logic       cy_out,
  output logic       zr_out,
  output logic       sg_out,
  output logic       pr_out
);

  alu_op_e           op_kind;
  res_src_e          res_src;
  logic              wr_acc;

  logic [DATA_W-1:0] bits_res;
  logic              bits_cy;
  logic [DATA_W-1:0] arith_res;
  logic              arith_cy;
  logic [DATA_W-1:0] dadj_res;
  logic              dadj_cy;
  logic              is_sub;
  logic              is_chain;

  logic [DATA_W-1:0] res;
  logic [DATA_W:0]   par_chain;
  alu_flags_t        flg_cur;
  alu_flags_t        flg_nxt;

  acc_alu_decode u_dec (
    .op_code (op_code),
    .op_kind (op_kind),
    .res_src (res_src),
    .wr_acc  (wr_acc)
  );

  acc_alu_bitops #(.W(DATA_W)) u_bits (
    .op_kind (op_kind),
    .a_in    (acc_in),
    .b_in    (opnd_in),
    .cy_in   (cy_in),
    .res_out (bits_res),
    .cy_out  (bits_cy)
  );

  assign is_sub   = (op_kind == ALU_SUB)  || (op_kind == ALU_SUBB);
  assign is_chain = (op_kind == ALU_ADDC) || (op_kind == ALU_SUBB);

  acc_alu_addsub #(.W(DATA_W)) u_arith (
    .a_in     (acc_in),
    .b_in     (opnd_in),
    .cy_in    (cy_in),
    .sub_en   (is_sub),
    .chain_en (is_chain),
    .sum_out  (arith_res),
    .cy_out   (arith_cy)
  );

  acc_alu_dadj u_dadj (
    .a_in    (acc_in),
    .cy_in   (cy_in),
    .res_out (dadj_res),
    .cy_out  (dadj_cy)
  );

  // Result selection
  always_comb begin
    case (res_src)
      SRC_BITS:  res = bits_res;
      SRC_ARITH: res = arith_res;
      SRC_DADJ:  res = dadj_res;
      default:   res = acc_in;
    endcase
  end

  // Odd-parity reduction as a chain of XOR stages
  assign par_chain[0] = 1'b0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res[i];
  end

  assign flg_cur = '{cy: cy_in, zr: zr_in, sg: sg_in, pr: pr_in};

  // Flag update
  always_comb begin
    flg_nxt = flg_cur;
    if (wr_acc) begin
      flg_nxt.zr = (res == '0);
      flg_nxt.sg = res[DATA_W-1];
      flg_nxt.pr = par_chain[DATA_W];
    end
    case (op_kind)
      ALU_ROLC, ALU_RORC:                   flg_nxt.cy = bits_cy;
      ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBB: flg_nxt.cy = arith_cy;
      ALU_DADJ:                             flg_nxt.cy = dadj_cy;
      ALU_CSET:                             flg_nxt.cy = 1'b1;
      ALU_CCLR:                             flg_nxt.cy = 1'b0;
      ALU_CINV:                             flg_nxt.cy = ~cy_in;
      default:                              flg_nxt.cy = cy_in;
    endcase
  end

  assign acc_out = res;
  assign acc_we  = wr_acc;
  assign cy_out  = flg_nxt.cy;
  assign zr_out  = flg_nxt.zr;
  assign sg_out  = flg_nxt.sg;
  assign pr_out  = flg_nxt.pr;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic [7:0] op_code,
  input logic [7:0] acc_in,
  input logic [7:0] opnd_in,
  input logic       cy_in,
  input logic       zr_in,
  input logic       sg_in,
  input logic       pr_in,
  input logic [7:0] acc_out,
  input logic       acc_we,
  input logic       cy_out,
  input logic       zr_out,
  input logic       sg_out,
  input logic       pr_out
);

  always_comb begin
    // R11: a non-writing opcode returns the accumulator untouched
    if (!acc_we) begin
      p_acc_hold_r11: assert (acc_out == acc_in)
        else $error("acc_out changed while write enable low");
    end
    // R8 and R11: non-writing opcodes keep zero, sign and parity
    if (!acc_we) begin
      p_zsp_hold_r8: assert (zr_out == zr_in && sg_out == sg_in && pr_out == pr_in)
        else $error("zero/sign/parity changed without accumulator write");
    end
    // R10: flag values derived from the written result
    if (acc_we) begin
      p_zero_r10: assert (zr_out == (acc_out == 8'h00))
        else $error("zero flag does not match result");
      p_sign_r10: assert (sg_out == acc_out[7])
        else $error("sign flag does not match result");
      p_parity_r10: assert (pr_out == (^acc_out))
        else $error("parity flag does not match result");
    end
    // R1: logical operations keep carry
    if (op_code[7:3] == 5'b10000 || op_code[7:3] == 5'b10001 || op_code[7:3] == 5'b10010) begin
      p_logic_cy_r1: assert (cy_out == cy_in && acc_we)
        else $error("logical op disturbed carry or did not write");
    end
    // R2: plain addition with carry out of bit 7
    if (op_code[7:3] == 5'b10100) begin
      p_add_r2: assert ({cy_out, acc_out} == ({1'b0, acc_in} + {1'b0, opnd_in}))
        else $error("addition result or carry wrong");
    end
    // R11: upper opcode quarter never writes, except the decimal adjust
    if (op_code[7:6] == 2'b11 && op_code != 8'hFA) begin
      p_upper_nowr_r11: assert (!acc_we && cy_out == cy_in)
        else $error("upper opcode wrote accumulator or carry");
    end
  end

endmodule

bind acc_alu acc_alu_chk u_chk (
  .op_code (op_code),
  .acc_in  (acc_in),
  .opnd_in (opnd_in),
  .cy_in   (cy_in),
  .zr_in   (zr_in),
  .sg_in   (sg_in),
  .pr_in   (pr_in),
  .acc_out (acc_out),
  .acc_we  (acc_we),
  .cy_out  (cy_out),
  .zr_out  (zr_out),
  .sg_out  (sg_out),
  .pr_out  (pr_out)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic       clk;
  logic       rst_n;
  logic [7:0] op_code;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic       cy_in, zr_in, sg_in, pr_in;
  logic [7:0] acc_out;
  logic       acc_we;
  logic       cy_out, zr_out, sg_out, pr_out;

  int n_chk;
  int n_bad;
  bit done;

  acc_alu uut (
    .op_code (op_code),
    .acc_in  (acc_in),
    .opnd_in (opnd_in),
    .cy_in   (cy_in),
    .zr_in   (zr_in),
    .sg_in   (sg_in),
    .pr_in   (pr_in),
    .acc_out (acc_out),
    .acc_we  (acc_we),
    .cy_out  (cy_out),
    .zr_out  (zr_out),
    .sg_out  (sg_out),
    .pr_out  (pr_out)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  // Row: opcode, A, operand, carry in, {zero,sign,parity} in,
  //      expected A, expected write enable, expected {carry,zero,sign,parity}
  localparam int NV = 31;
  localparam logic [40:0] VEC [NV] = '{
    {8'h80, 8'hF0, 8'h3C, 1'b1, 3'b000, 8'h30, 1'b1, 4'b1000},
    {8'h8D, 8'h00, 8'h00, 1'b0, 3'b000, 8'h00, 1'b1, 4'b0100},
    {8'h96, 8'hA5, 8'hFF, 1'b0, 3'b000, 8'h5A, 1'b1, 4'b0000},
    {8'hA0, 8'hC8, 8'h64, 1'b0, 3'b000, 8'h2C, 1'b1, 4'b1001},
    {8'hA6, 8'h7F, 8'h01, 1'b1, 3'b000, 8'h80, 1'b1, 4'b0011},
    {8'hAF, 8'hFF, 8'h00, 1'b1, 3'b000, 8'h00, 1'b1, 4'b1100},
    {8'hA8, 8'h10, 8'h20, 1'b0, 3'b000, 8'h30, 1'b1, 4'b0000},
    {8'hB0, 8'h10, 8'h20, 1'b1, 3'b000, 8'hF0, 1'b1, 4'b1010},
    {8'hB5, 8'h50, 8'h50, 1'b0, 3'b000, 8'h00, 1'b1, 4'b0100},
    {8'hB8, 8'h50, 8'h50, 1'b1, 3'b000, 8'hFF, 1'b1, 4'b1010},
    {8'hBF, 8'h81, 8'h01, 1'b1, 3'b000, 8'h7F, 1'b1, 4'b0001},
    {8'h98, 8'h81, 8'hFF, 1'b0, 3'b000, 8'h03, 1'b1, 4'b0000},
    {8'h99, 8'h81, 8'h00, 1'b0, 3'b000, 8'h02, 1'b1, 4'b1001},
    {8'h9A, 8'h01, 8'h00, 1'b0, 3'b000, 8'h80, 1'b1, 4'b0011},
    {8'h9B, 8'h01, 8'h00, 1'b0, 3'b000, 8'h00, 1'b1, 4'b1100},
    {8'h9B, 8'h02, 8'h00, 1'b1, 3'b000, 8'h81, 1'b1, 4'b0010},
    {8'h9E, 8'hFF, 8'hAA, 1'b0, 3'b000, 8'h00, 1'b1, 4'b0100},
    {8'h9F, 8'h00, 8'hAA, 1'b1, 3'b000, 8'hFF, 1'b1, 4'b1010},
    {8'h0F, 8'h55, 8'h00, 1'b1, 3'b000, 8'hAA, 1'b1, 4'b1010},
    {8'h08, 8'h33, 8'h00, 1'b0, 3'b101, 8'h33, 1'b0, 4'b1101},
    {8'h09, 8'h33, 8'h00, 1'b1, 3'b010, 8'h33, 1'b0, 4'b0010},
    {8'h0E, 8'h33, 8'h00, 1'b1, 3'b000, 8'h33, 1'b0, 4'b0000},
    {8'hFA, 8'h9A, 8'hFF, 1'b0, 3'b000, 8'h00, 1'b1, 4'b1100},
    {8'hFA, 8'h15, 8'h00, 1'b0, 3'b000, 8'h15, 1'b1, 4'b0001},
    {8'hFA, 8'h0C, 8'h00, 1'b0, 3'b000, 8'h12, 1'b1, 4'b0000},
    {8'hFA, 8'h23, 8'h00, 1'b1, 3'b000, 8'h83, 1'b1, 4'b1011},
    {8'hFA, 8'hA0, 8'h00, 1'b0, 3'b000, 8'h00, 1'b1, 4'b1100},
    {8'h00, 8'h77, 8'h00, 1'b1, 3'b011, 8'h77, 1'b0, 4'b1011},
    {8'h9C, 8'h44, 8'h00, 1'b0, 3'b100, 8'h44, 1'b0, 4'b0100},
    {8'hFF, 8'h12, 8'h00, 1'b1, 3'b000, 8'h12, 1'b0, 4'b1000},
    {8'hC3, 8'h01, 8'h00, 1'b0, 3'b111, 8'h01, 1'b0, 4'b0111}
  };

  function automatic string req_of(input logic [7:0] op);
    if (op >= 8'h80 && op <= 8'h97)      return "R1/R10";
    if (op >= 8'hA0 && op <= 8'hA7)      return "R2/R10";
    if (op >= 8'hA8 && op <= 8'hAF)      return "R3/R10";
    if (op >= 8'hB0 && op <= 8'hB7)      return "R4/R10";
    if (op >= 8'hB8 && op <= 8'hBF)      return "R5/R10";
    if (op >= 8'h98 && op <= 8'h9B)      return "R6/R10";
    if (op == 8'h9E || op == 8'h9F || op == 8'h0F) return "R7/R10";
    if (op == 8'h08 || op == 8'h09 || op == 8'h0E) return "R8";
    if (op == 8'hFA)                     return "R9/R10";
    return "R11";
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic [2:0] zsp);
    @(posedge clk);
    #1ns;
    op_code = op;
    acc_in  = a;
    opnd_in = b;
    cy_in   = ci;
    {zr_in, sg_in, pr_in} = zsp;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] ea, input logic ewe,
                       input logic [3:0] ef);
    n_chk++;
    if (acc_out !== ea || acc_we !== ewe || {cy_out, zr_out, sg_out, pr_out} !== ef) begin
      n_bad++;
      $display("FAIL %s op=%02h: got acc=%02h we=%0b czsp=%04b, expected acc=%02h we=%0b czsp=%04b",
               req, op_code, acc_out, acc_we, {cy_out, zr_out, sg_out, pr_out}, ea, ewe, ef);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    op_code = 8'h00;
    acc_in  = 8'h00;
    opnd_in = 8'h00;
    cy_in   = 1'b0;
    zr_in   = 1'b0;
    sg_in   = 1'b0;
    pr_in   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: idle opcode during reset gives a pass-through with no write
    check("R11 reset", 8'h00, 1'b0, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      drive(v[40:33], v[32:25], v[24:17], v[16], v[15:13]);
      check(req_of(v[40:33]), v[12:5], v[4], v[3:0]);
    end

    // R2 sweep: every accumulator value against a varying operand
    for (int a = 0; a < 256; a++) begin
      logic [7:0] av, bv, r;
      logic [8:0] w;
      av = 8'(a);
      bv = av ^ 8'h5A;
      w  = {1'b0, av} + {1'b0, bv};
      r  = w[7:0];
      drive(8'hA3, av, bv, 1'b1, 3'b000);
      check("R2/R10 sweep", r, 1'b1, {w[8], r == 8'h00, r[7], ^r});
    end

    // R5 sweep: subtract with borrow-in across every accumulator value
    for (int a = 0; a < 256; a++) begin
      logic [7:0] av, r;
      logic [8:0] w;
      av = 8'(a);
      w  = {1'b0, av} - 9'h03C - 9'h001;
      r  = w[7:0];
      drive(8'hBB, av, 8'h3C, 1'b1, 3'b000);
      check("R5/R10 sweep", r, 1'b1, {w[8], r == 8'h00, r[7], ^r});
    end

    // R1: low opcode bits do not alter the logical operation
    for (int k = 0; k < 8; k++) begin
      drive(8'h88 | 8'(k), 8'h0C, 8'h30, 1'b0, 3'b111);
      check("R1 low bits", 8'h3C, 1'b1, 4'b0000);
    end

    // R11: decrement-pointer opcode is not an accumulator operation
    drive(8'h9D, 8'h00, 8'h00, 1'b1, 3'b010);
    check("R11 9D", 8'h00, 1'b0, 4'b1010);

    finish_run();
  end

endmodule